// File: doc/BRIEF.md
# Soft-Start and Output Fault Supervisor

This block supervises start-up and output protection for a buck regulator controller. When enabled, it raises the permitted valley current limit in four equal stages. Each stage lasts a fixed number of switching clock pulses. It also keeps under-voltage detection blanked for a longer stretch of switching pulses. Once running, it qualifies the over-voltage and under-voltage comparator flags over a programmable number of system clocks. It latches a qualified fault and turns the latch into gate override commands for the driver stage.

An over-voltage fault forces the low-side switch on to discharge the output. An under-voltage fault forces both switches off. While that fault is latched, the low side is pulsed on only while the phase node stays above 1 V, which drains residual charge. When the output voltage select code changes, both fault checks are suspended for a set number of switching pulses while the output moves to its new level. Latched faults survive supply lockout and clear only on a power-on reset or when enable is dropped.

Top module: `ss_fault_sup`

## Requirements
- R1: After reset with `en` low, the outputs are `ilim_step`=0, `ss_done`=0, `gate_off_both`=1, `lo_force_on`=0, `ov_fault`=0 and `uv_fault`=0.
- R2: While `uvlo` is high, `gate_off_both`=1 and `lo_force_on`=0, whatever faults are latched. The soft-start count returns to zero and stays there, so `ilim_step` reads 0.
- R3: The block runs while `en` is high and `por` and `uvlo` are low. While it runs, let n be the number of clocks with `sw_tick` high. Then `ilim_step` = min(n / STEP_TICKS, 3), where code 0, 1, 2, 3 means 25 %, 50 %, 75 %, 100 % of the limit. `ss_done` is 1 exactly when n >= 4*STEP_TICKS.
- R4: While n < UV_BLANK_TICKS, `uv_cmp` is ignored and `uv_fault` stays 0. Qualification starts on the first clock after n reaches the limit.
- R5: `ov_fault` sets after the OV_QUAL_CYC-th consecutive armed clock edge with `ov_cmp` high. A shorter run sets nothing, and a low clock restarts the count.
- R6: While the block runs with `ov_fault` set, `lo_force_on`=1 and `gate_off_both`=0. The latch holds after `ov_cmp` falls.
- R7: Both fault latches clear on a clock edge where `por` is high or `en` is low, and only then. `uvlo` does not clear them.
- R8: `uv_fault` sets after UV_QUAL_CYC consecutive armed edges with `uv_cmp` high. With `phase_hi` low it gives `gate_off_both`=1 and `lo_force_on`=0.
- R9: While the block runs with `uv_fault` set, `lo_force_on` equals `phase_hi` and `gate_off_both` equals its inverse, in the same cycle.
- R10: A change of `vsel` masks both comparators. The mask starts in the cycle of the change and lasts until MASK_TICKS `sw_tick` pulses have followed it. Comparator activity under the mask sets no fault.
- R11: If both faults qualify in the same cycle, only `ov_fault` sets. A fault that is already latched blocks the other from setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Controller enable; low clears faults and soft-start |
| por | input | 1 | Supply power-on-reset flag; high clears faults |
| uvlo | input | 1 | Supply undervoltage lockout flag |
| sw_tick | input | 1 | One-clock pulse per switching cycle |
| vsel | input | VSEL_W | Output voltage select code |
| ov_cmp | input | 1 | Output above over-voltage threshold |
| uv_cmp | input | 1 | Output below under-voltage threshold |
| phase_hi | input | 1 | Phase node above 1 V |
| ilim_step | output | 2 | Current limit stage code (0..3 = 25..100 %) |
| ss_done | output | 1 | Soft-start ramp complete |
| gate_off_both | output | 1 | Force both gates low |
| lo_force_on | output | 1 | Force low-side gate on (high side off) |
| ov_fault | output | 1 | Latched over-voltage fault |
| uv_fault | output | 1 | Latched under-voltage fault |

## Verification
The bench builds the block with STEP_TICKS=4, UV_BLANK_TICKS=12, MASK_TICKS=3 and both qualification lengths at 4 system clocks. With these values the whole ramp, the blanking edge and the mask release take a few dozen cycles. That lets the bench sweep every ramp position and every comparator run length around the qualification threshold. Because the two qualification lengths are equal, both faults can qualify on the same edge, which makes the priority rule directly observable.

// File: rtl/ss_fault_pkg.sv
// Shared types and helpers for the soft-start and fault supervisor.
// Assumes a four-stage current limit ramp encoded in two bits.
package ss_fault_pkg;
    localparam int ILIM_LEVELS = 4;
    typedef logic [1:0] ilim_code_t;
    localparam ilim_code_t ILIM_FULL = 2'd3;

    // Larger of two integers, for parameter derivation.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/ss_ramp.sv
// Soft-start ramp: counts switching pulses while running and derives the
// current limit stage, the done flag and the under-voltage blanking window.
// Assumes sw_tick is a single-clock pulse; the count saturates.
module ss_ramp
    import ss_fault_pkg::*;
#(
    parameter int STEP_TICKS     = 128,
    parameter int UV_BLANK_TICKS = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       sw_tick,
    output ilim_code_t ilim_step,
    output logic       done,
    output logic       uv_blank
);
    localparam int SS_TICKS = STEP_TICKS * ILIM_LEVELS;
    localparam int CNT_MAX  = max2(SS_TICKS, UV_BLANK_TICKS);
    localparam int CW       = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] STEP_W  = CW'(STEP_TICKS);
    localparam logic [CW-1:0] SS_W    = CW'(SS_TICKS);
    localparam logic [CW-1:0] BLANK_W = CW'(UV_BLANK_TICKS);
    localparam logic [CW-1:0] MAX_W   = CW'(CNT_MAX);

    logic [CW-1:0] cnt;

    // Count switching pulses while running, restart when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (sw_tick && cnt != MAX_W) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Decode stage, completion and blanking from the count.
    always_comb begin
        done     = (cnt >= SS_W);
        uv_blank = (cnt < BLANK_W);
        if (done) begin
            ilim_step = ILIM_FULL;
        end else begin
            ilim_step = ilim_code_t'(cnt / STEP_W);
        end
    end
endmodule

// File: rtl/vsel_mask.sv
// Voltage-select change mask: holds both fault checks off from the cycle a
// new code appears until MASK_TICKS switching pulses have followed it.
// Assumes the code held during reset is the starting code (no mask then).
module vsel_mask #(
    parameter int VSEL_W     = 3,
    parameter int MASK_TICKS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_tick,
    input  logic [VSEL_W-1:0] vsel,
    output logic              masked
);
    localparam int MW = $clog2(MASK_TICKS + 1);
    localparam logic [MW-1:0] MASK_W = MW'(MASK_TICKS);

    logic [VSEL_W-1:0] vsel_q;
    logic [MW-1:0]     mcnt;
    logic              changed;

    // Compare the live code against the previous one.
    always_comb changed = (vsel != vsel_q);

    // Track the code and run the mask countdown on switching pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vsel_q <= vsel;
            mcnt   <= '0;
        end else begin
            vsel_q <= vsel;
            if (changed) begin
                mcnt <= MASK_W;
            end else if (sw_tick && mcnt != '0) begin
                mcnt <= mcnt - 1'b1;
            end
        end
    end

    // Mask covers the change cycle and the countdown.
    always_comb masked = changed || (mcnt != '0);
endmodule

// File: rtl/fault_qual.sv
// Fault qualifier: reports a hit once a comparator flag has been high for
// QUAL_CYC consecutive armed clocks. Any gap or disarm restarts the count.
// Assumes QUAL_CYC >= 1.
module fault_qual #(
    parameter int QUAL_CYC = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic cond,
    output logic hit
);
    localparam int QW = (QUAL_CYC > 1) ? $clog2(QUAL_CYC) : 1;
    localparam logic [QW-1:0] LAST = QW'(QUAL_CYC - 1);

    logic [QW-1:0] cnt;
    logic          live;

    // Condition counts only while armed.
    always_comb live = arm && cond;

    // Hit on the edge that completes the qualification run.
    always_comb hit = live && (cnt == LAST);

    // Count consecutive live clocks, holding at the last value.
    always_ff @(posedge clk) begin
        if (!rst_n || !live) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ss_fault_sup.sv
// Soft-start and output fault supervisor for a buck controller. It ramps the
// current limit, qualifies and latches output faults and drives the gate
// overrides. Assumes all inputs are synchronous to clk.
module ss_fault_sup
    import ss_fault_pkg::*;
#(
    parameter int VSEL_W         = 3,
    parameter int STEP_TICKS     = 128,
    parameter int UV_BLANK_TICKS = 512,
    parameter int MASK_TICKS     = 32,
    parameter int OV_QUAL_CYC    = 5000,
    parameter int UV_QUAL_CYC    = 625
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              por,
    input  logic              uvlo,
    input  logic              sw_tick,
    input  logic [VSEL_W-1:0] vsel,
    input  logic              ov_cmp,
    input  logic              uv_cmp,
    input  logic              phase_hi,
    output logic [1:0]        ilim_step,
    output logic              ss_done,
    output logic              gate_off_both,
    output logic              lo_force_on,
    output logic              ov_fault,
    output logic              uv_fault
);
    logic       run, clr;
    logic       uv_blank, masked;
    logic       arm_ov, arm_uv;
    logic       ov_hit, uv_hit;
    logic       ov_set, uv_set;
    ilim_code_t step_code;

    // Operating and clearing conditions.
    always_comb begin
        run = en && !por && !uvlo;
        clr = !en || por;
    end

    ss_ramp #(
        .STEP_TICKS    (STEP_TICKS),
        .UV_BLANK_TICKS(UV_BLANK_TICKS)
    ) ramp_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .sw_tick  (sw_tick),
        .ilim_step(step_code),
        .done     (ss_done),
        .uv_blank (uv_blank)
    );

    vsel_mask #(
        .VSEL_W    (VSEL_W),
        .MASK_TICKS(MASK_TICKS)
    ) mask_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_tick(sw_tick),
        .vsel   (vsel),
        .masked (masked)
    );

    // Arm the qualifiers only when running and unmasked.
    always_comb begin
        arm_ov = run && !masked;
        arm_uv = run && !masked && !uv_blank;
    end

    fault_qual #(.QUAL_CYC(OV_QUAL_CYC)) ovq_i (
        .clk  (clk),
        .rst_n(rst_n),
        .arm  (arm_ov),
        .cond (ov_cmp),
        .hit  (ov_hit)
    );

    fault_qual #(.QUAL_CYC(UV_QUAL_CYC)) uvq_i (
        .clk  (clk),
        .rst_n(rst_n),
        .arm  (arm_uv),
        .cond (uv_cmp),
        .hit  (uv_hit)
    );

    // Priority: over-voltage wins a tie, and a latched fault blocks the other.
    always_comb begin
        ov_set = ov_hit && !uv_fault;
        uv_set = uv_hit && !ov_hit && !ov_fault;
    end

    // Fault latches, cleared only by power-on reset or disable.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ov_fault <= 1'b0;
            uv_fault <= 1'b0;
        end else begin
            ov_fault <= ov_fault || ov_set;
            uv_fault <= uv_fault || uv_set;
        end
    end

    // Gate overrides and the current limit stage.
    always_comb begin
        ilim_step     = step_code;
        lo_force_on   = run && (ov_fault || (uv_fault && phase_hi));
        gate_off_both = !run || (uv_fault && !phase_hi && !ov_fault);
    end
endmodule

// File: rtl/ss_fault_sup_chk.sv
// Property checker for ss_fault_sup, attached through bind below.
// Assumes the synchronous active-low reset of the supervised block.
module ss_fault_sup_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       por,
    input logic       uvlo,
    input logic [1:0] ilim_step,
    input logic       ss_done,
    input logic       gate_off_both,
    input logic       lo_force_on,
    input logic       ov_fault,
    input logic       uv_fault
);
    AST_UVLO_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo |-> (gate_off_both && !lo_force_on)); // R2

    AST_OVERRIDES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_off_both && lo_force_on)); // R9

    AST_STEP_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en && !por && !uvlo) && (en && !por && !uvlo) |-> (ilim_step >= $past(ilim_step))); // R3

    AST_DONE_FULL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ss_done |-> (ilim_step == 2'd3)); // R3

    AST_OV_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ov_fault && en && !por) |-> ov_fault); // R6

    AST_UV_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(uv_fault && en && !por) |-> uv_fault); // R7

    AST_FAULT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!en || por) |-> (!ov_fault && !uv_fault)); // R7

    AST_FAULTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ov_fault && uv_fault)); // R11
endmodule

bind ss_fault_sup ss_fault_sup_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .por          (por),
    .uvlo         (uvlo),
    .ilim_step    (ilim_step),
    .ss_done      (ss_done),
    .gate_off_both(gate_off_both),
    .lo_force_on  (lo_force_on),
    .ov_fault     (ov_fault),
    .uv_fault     (uv_fault)
);

// File: tb/ss_fault_sup_tb_top.sv
// Self-checking bench for ss_fault_sup with a small configuration.
module ss_fault_sup_tb_top;
    localparam int VSEL_W = 3;
    localparam int STEP   = 4;
    localparam int BLANK  = 12;
    localparam int MASK   = 3;
    localparam int OVQ    = 4;
    localparam int UVQ    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, por = 1'b0, uvlo = 1'b0, sw_tick = 1'b0;
    logic [VSEL_W-1:0] vsel = '0;
    logic ov_cmp = 1'b0, uv_cmp = 1'b0, phase_hi = 1'b0;
    logic [1:0] ilim_step;
    logic ss_done, gate_off_both, lo_force_on, ov_fault, uv_fault;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ss_fault_sup #(
        .VSEL_W(VSEL_W), .STEP_TICKS(STEP), .UV_BLANK_TICKS(BLANK),
        .MASK_TICKS(MASK), .OV_QUAL_CYC(OVQ), .UV_QUAL_CYC(UVQ)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .por(por), .uvlo(uvlo),
        .sw_tick(sw_tick), .vsel(vsel), .ov_cmp(ov_cmp), .uv_cmp(uv_cmp),
        .phase_hi(phase_hi), .ilim_step(ilim_step), .ss_done(ss_done),
        .gate_off_both(gate_off_both), .lo_force_on(lo_force_on),
        .ov_fault(ov_fault), .uv_fault(uv_fault)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            sw_tick = 1'b1;
            cyc(1);
            sw_tick = 1'b0;
            cyc(1);
        end
    endtask

    task automatic restart();
        ov_cmp = 1'b0;
        uv_cmp = 1'b0;
        en = 1'b0;
        cyc(2);
        en = 1'b1;
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset / disabled state
        chk("R1 ilim_step", ilim_step, 0);
        chk("R1 ss_done", ss_done, 0);
        chk("R1 gate_off_both", gate_off_both, 1);
        chk("R1 lo_force_on", lo_force_on, 0);
        chk("R1 faults", {ov_fault, uv_fault}, 0);

        // R3 ramp sweep over every tick position
        restart();
        for (int n = 0; n <= 4 * STEP + 2; n++) begin
            chk("R3 ilim_step", ilim_step, (n / STEP > 3) ? 3 : n / STEP);
            chk("R3 ss_done", ss_done, (n >= 4 * STEP) ? 1 : 0);
            ticks(1);
        end

        // R2 lockout resets the ramp and forces gates low
        restart();
        ticks(STEP + 1);
        chk("R2 pre step", ilim_step, 1);
        uvlo = 1'b1;
        cyc(1);
        chk("R2 step reset", ilim_step, 0);
        ticks(2);
        chk("R2 step held", ilim_step, 0);
        chk("R2 gate_off_both", gate_off_both, 1);
        uvlo = 1'b0;
        cyc(1);

        // R5 qualification length sweep, R6 action
        for (int len = 1; len <= OVQ + 1; len++) begin
            restart();
            ov_cmp = 1'b1;
            cyc(len);
            ov_cmp = 1'b0;
            chk("R5 ov_fault", ov_fault, (len >= OVQ) ? 1 : 0);
            cyc(2);
            chk("R6 ov held", ov_fault, (len >= OVQ) ? 1 : 0);
            chk("R6 lo_force_on", lo_force_on, (len >= OVQ) ? 1 : 0);
            chk("R6 gate_off_both", gate_off_both, 0);
        end
        // R5 gap restarts count
        restart();
        ov_cmp = 1'b1; cyc(OVQ - 1);
        ov_cmp = 1'b0; cyc(1);
        ov_cmp = 1'b1; cyc(OVQ - 1);
        ov_cmp = 1'b0;
        chk("R5 gap no fault", ov_fault, 0);
        ov_cmp = 1'b1; cyc(OVQ);
        ov_cmp = 1'b0;
        chk("R5 full run", ov_fault, 1);

        // R7 lockout keeps the latch, power-on reset clears it
        uvlo = 1'b1;
        cyc(2);
        chk("R2 uvlo with ov", lo_force_on, 0);
        chk("R7 uvlo keeps ov", ov_fault, 1);
        uvlo = 1'b0;
        cyc(1);
        chk("R6 lo_force_on back", lo_force_on, 1);
        por = 1'b1;
        cyc(1);
        por = 1'b0;
        chk("R7 por clears ov", ov_fault, 0);

        // R4 blanking edge
        restart();
        uv_cmp = 1'b1;
        ticks(BLANK - 1);
        cyc(UVQ + 2);
        chk("R4 blanked", uv_fault, 0);
        ticks(1);
        if (UVQ > 2) cyc(UVQ - 2);
        chk("R4 just before", uv_fault, 0);
        cyc(1);
        chk("R4 after blank", uv_fault, 1);

        // R8 action, R9 phase follow
        restart();
        ticks(BLANK);
        uv_cmp = 1'b1;
        cyc(UVQ - 1);
        chk("R8 early", uv_fault, 0);
        cyc(1);
        chk("R8 uv_fault", uv_fault, 1);
        chk("R8 gate_off_both", gate_off_both, 1);
        chk("R8 lo_force_on", lo_force_on, 0);
        uv_cmp = 1'b0;
        for (int p = 0; p < 4; p++) begin
            phase_hi = p[0];
            #1;
            chk("R9 lo_force_on", lo_force_on, p[0]);
            chk("R9 gate_off_both", gate_off_both, !p[0]);
            cyc(1);
        end
        phase_hi = 1'b0;
        uvlo = 1'b1; cyc(2); uvlo = 1'b0; cyc(1);
        chk("R7 uv kept over uvlo", uv_fault, 1);
        en = 1'b0; cyc(1); en = 1'b1; cyc(1);
        chk("R7 en clears uv", uv_fault, 0);

        // R10 mask on over-voltage with exact release
        restart();
        ticks(BLANK);
        vsel = vsel + 1'b1;
        ov_cmp = 1'b1;
        cyc(OVQ + 2);
        chk("R10 ov masked", ov_fault, 0);
        ticks(MASK - 1);
        chk("R10 ov still masked", ov_fault, 0);
        ticks(1);
        if (OVQ > 2) cyc(OVQ - 2);
        chk("R10 release edge", ov_fault, 0);
        cyc(1);
        chk("R10 ov after mask", ov_fault, 1);

        // R10 mask on under-voltage
        restart();
        ticks(BLANK);
        vsel = vsel + 1'b1;
        uv_cmp = 1'b1;
        cyc(UVQ + 3);
        chk("R10 uv masked", uv_fault, 0);
        ticks(MASK);
        cyc(UVQ + 1);
        chk("R10 uv after mask", uv_fault, 1);

        // R11 same-cycle tie and blocking
        restart();
        ticks(BLANK);
        ov_cmp = 1'b1; uv_cmp = 1'b1;
        cyc(OVQ);
        chk("R11 tie ov", ov_fault, 1);
        chk("R11 tie uv", uv_fault, 0);
        restart();
        ticks(BLANK);
        uv_cmp = 1'b1;
        cyc(UVQ);
        uv_cmp = 1'b0;
        ov_cmp = 1'b1;
        cyc(OVQ + 2);
        chk("R11 uv blocks ov", ov_fault, 0);
        chk("R11 uv kept", uv_fault, 1);
        ov_cmp = 1'b0;

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog all actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule